// File: doc/BRIEF.md
# CCD Windowed Readout Sequencer

This block clocks one frame out of a full-frame CCD. It moves charge down the array with three-phase image clocks and across the serial register with three-phase serial clocks. Rows above and below a rectangular region of interest are dumped through the dump drain. Rows inside the region are summed in the serial register by shifting several rows before each serial readout. Pixels inside the region are summed on the output node by holding off the amplifier reset. Pixels outside the region, and the lead-in pixels at the start of the register, are moved at a faster rate and are not sampled. Extra pixels past the end of the register and extra virtual rows past the end of the array can be read to measure offset and transfer loss.

The host sets the window, the binning, the overclock counts, the readout port and the integration phase pattern, then pulses start. A flush pulse empties the whole array through the dump drain and takes no samples. Each sample strobe names the amplifier or amplifiers it comes from and carries the binned column and row index of the pixel, so the ADC side can place it. While idle, the image clocks hold the integration pattern. The done flag rises when a frame ends and stays high until the next frame is accepted.

Top module: `ccd_readout_seq`

## Requirements
- R1: While reset is held, iphi_o follows integ_phase_i, and sphi_o, dump_o, amp_rst_o, sample_o and done_o are all zero.
- R2: Rows before row_start_i and rows after the window are each shifted with dump_o high. Over a frame, dump_o is high for 3*ROW_PH*(ROWS - rows shifted inside the window) cycles. A flush_i pulse dumps all ROWS rows and makes no samples.
- R3: A row shift lasts 3*ROW_PH cycles. A read pixel lasts 3*PIX_PH cycles and a skipped pixel lasts 3*FAST_PH cycles. During each step, a single phase is high and the phases advance 001, 010, 100. Consecutive steps follow with no gap. From the clock edge that accepts start to the edge that raises done_o, exactly 1 + the sum of the step lengths elapses.
- R4: Every binned window pixel makes one sample_o pulse in the last cycle of its final packet. Samples arrive in order: row by row, and column 0 upward within a row. col_o and row_o give the binned column and row index.
- R5: Within a column bin of bin_col_i packets, amp_rst_o pulses (it is high for the whole of phase 1) only before the first packet. Every other pixel gets one reset pulse, and the reset pulse never coincides with sample_o.
- R6: For each output row of the window, bin_row_i rows are shifted into the serial register before that row's serial readout.
- R7: port_sel_i bit 0 selects the left amplifier and bit 1 the right amplifier. Code 00 acts as left. sample_o carries the port mask. With both ports, each half of the register is LEAD + COLS/2 pixels long. With one port it is LEAD + COLS.
- R8: oc_cols_i pixels past the end of the register half are read at the normal rate and sampled one per pixel, with col_o = win_cols + k.
- R9: After the last physical row has been dumped, oc_rows_i virtual rows are shifted and read out. Their row_o continues from the window row count.
- R10: A bin_row_i or bin_col_i value of 0 is treated as 1.
- R11: done_o stays high from the end of a frame until the next start or flush is accepted, and the image clocks then follow integ_phase_i. start_i, flush_i and configuration changes during a frame have no effect on that frame.
- R12: sphi_o is at most one-hot and is zero during row shifts and dumps.
- R13: A win_rows_i value above MAX_WIN_ROWS is reduced to MAX_WIN_ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame, taken only while idle |
| flush_i | input | 1 | Dump the whole array, taken only while idle |
| port_sel_i | input | 2 | Amplifier select: bit 0 left, bit 1 right |
| integ_phase_i | input | 3 | Image phases held high during integration |
| row_start_i | input | RW | Rows dumped before the window |
| win_rows_i | input | RW | Window height in binned rows |
| bin_row_i | input | RW | Rows summed per output row |
| col_start_i | input | CW | First window column within the register half |
| win_cols_i | input | CW | Window width in binned columns |
| bin_col_i | input | CW | Packets summed per output pixel |
| oc_cols_i | input | CW | Overclocked pixels per row |
| oc_rows_i | input | RW | Virtual rows after the array |
| iphi_o | output | 3 | Image clock phases |
| sphi_o | output | 3 | Serial clock phases |
| dump_o | output | 1 | Dump drain gate |
| amp_rst_o | output | 1 | Output amplifier reset pulse |
| sample_o | output | 2 | ADC sample strobe per amplifier |
| col_o | output | CW | Binned column index of the sample |
| row_o | output | RW | Binned row index of the sample |
| done_o | output | 1 | Frame finished |

## Verification
The main function is run with windows placed at the top, middle and bottom-right corner of the array. It is also run with row and column binning separately, together and at full-array size, and with each port setting including the unused code. The overclock counts are tried both zero and non-zero, including a frame with no window rows at all. Frame length separates errors in step timing and in the skip/read choice. The dump-cycle count separates errors in row binning from errors in window placement. The sample order and indices catch mistakes in the binning counters and in the overclock offsets. The reset-pulse count is the only measure that sees whether the amplifier reset is suppressed correctly inside a bin.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_RUN} seq_st_e;
  typedef enum logic [1:0] {SK_DUMP, SK_SHIFT, SK_FAST, SK_READ} step_e;

  function automatic logic [2:0] phase_onehot(input logic [1:0] ph);
    return 3'b001 << ph;
  endfunction
endpackage

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen #(
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          active_o,
  output logic [1:0]    ph_o,
  output logic          end_o
);
  logic [LW-1:0] tcnt_q, len_q;
  logic [1:0]    ph_q;
  logic          act_q;

  assign active_o = act_q;
  assign ph_o     = ph_q;
  assign end_o    = act_q && (ph_q == 2'd2) && (tcnt_q == len_q - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ph_q   <= 2'd0;
      tcnt_q <= '0;
      len_q  <= LW'(1);
    end else if (start_i) begin
      act_q  <= 1'b1;
      ph_q   <= 2'd0;
      tcnt_q <= '0;
      len_q  <= (len_i == '0) ? LW'(1) : len_i;
    end else if (act_q) begin
      if (tcnt_q == len_q - LW'(1)) begin
        tcnt_q <= '0;
        if (ph_q == 2'd2) act_q <= 1'b0;
        else              ph_q  <= ph_q + 2'd1;
      end else begin
        tcnt_q <= tcnt_q + LW'(1);
      end
    end
  end

  a_r3_tick_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (tcnt_q < len_q) && (ph_q != 2'd3));
endmodule

// File: rtl/ccd_col_walk.sv
module ccd_col_walk #(
  parameter int CW   = 12,
  parameter int LEAD = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          adv_i,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] col_start_i,
  input  logic [CW-1:0] win_cols_i,
  input  logic [CW-1:0] bin_col_i,
  input  logic [CW-1:0] oc_cols_i,
  output logic          fast_o,
  output logic          rst_o,
  output logic          smp_o,
  output logic [CW-1:0] col_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD);

  logic [CW-1:0] pos_q, widx_q, sub_q, img_c;
  logic in_lead, in_img, in_win, in_ovc, sub_last;

  always_comb begin
    in_lead  = pos_q < LEAD_C;
    in_img   = !in_lead && (pos_q < LEAD_C + half_i);
    in_ovc   = !in_lead && !in_img;
    img_c    = pos_q - LEAD_C;
    in_win   = in_img && (img_c >= col_start_i) && (widx_q < win_cols_i);
    sub_last = sub_q == bin_col_i - CW'(1);
    fast_o   = !(in_win || in_ovc);
    rst_o    = !(in_win && (sub_q != '0));
    smp_o    = (in_win && sub_last) || in_ovc;
    col_o    = in_ovc ? win_cols_i + (pos_q - LEAD_C - half_i) : widx_q;
    last_o   = pos_q == LEAD_C + half_i + oc_cols_i - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      widx_q <= '0;
      sub_q  <= '0;
    end else if (init_i) begin
      pos_q  <= '0;
      widx_q <= '0;
      sub_q  <= '0;
    end else if (adv_i) begin
      pos_q <= pos_q + CW'(1);
      if (in_win) begin
        if (sub_last) begin
          sub_q  <= '0;
          widx_q <= widx_q + CW'(1);
        end else begin
          sub_q <= sub_q + CW'(1);
        end
      end
    end
  end

  // R5: packet counter never runs past the bin size
  a_r5_sub_in_bin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !(in_win && (sub_q >= bin_col_i)));
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int COLS         = 2048,
  parameter int LEAD         = 50,
  parameter int ROWS         = 1024,
  parameter int MAX_WIN_ROWS = 512,
  parameter int CW           = 12,
  parameter int RW           = 12,
  parameter int LW           = 4,
  parameter int ROW_PH       = 8,
  parameter int PIX_PH       = 2,
  parameter int FAST_PH      = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          flush_i,
  input  logic [1:0]    port_sel_i,
  input  logic [2:0]    integ_phase_i,
  input  logic [RW-1:0] row_start_i,
  input  logic [RW-1:0] win_rows_i,
  input  logic [RW-1:0] bin_row_i,
  input  logic [CW-1:0] col_start_i,
  input  logic [CW-1:0] win_cols_i,
  input  logic [CW-1:0] bin_col_i,
  input  logic [CW-1:0] oc_cols_i,
  input  logic [RW-1:0] oc_rows_i,
  output logic [2:0]    iphi_o,
  output logic [2:0]    sphi_o,
  output logic          dump_o,
  output logic          amp_rst_o,
  output logic [1:0]    sample_o,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic          done_o
);
  localparam logic [CW-1:0] HALF_FULL  = CW'(COLS);
  localparam logic [CW-1:0] HALF_SPLIT = CW'(COLS / 2);
  localparam logic [RW-1:0] ROWS_C     = RW'(ROWS);
  localparam logic [RW-1:0] MAXW_C     = RW'(MAX_WIN_ROWS);

  seq_st_e st_q;
  step_e   kind_q;
  logic [1:0]    port_q;
  logic [2:0]    integ_q;
  logic [RW-1:0] rs_q, wr_q, br_q, ocr_q, phys_q, wrow_q, brow_q, ocnt_q, row_q;
  logic [CW-1:0] cs_q, wc_q, bc_q, occ_q, col_q, half;
  logic          flush_q, ser_q, step_rst_q, step_smp_q, done_q;

  logic g_start, g_active, g_end;
  logic [1:0] g_ph;
  logic [LW-1:0] g_len;
  logic w_init, w_adv, w_fast, w_rst, w_smp, w_last;
  logic [CW-1:0] w_col;
  logic adv, dec_pix, dec_pre, dec_win, dec_post, dec_ovr, dec_fin, bin_full;
  logic row_step, pix_step;

  assign half = (port_q == 2'b11) ? HALF_SPLIT : HALF_FULL;

  // next-step priority: serial walk, pre-dump, window rows, post-dump, virtual rows
  always_comb begin
    adv      = (st_q == ST_LAUNCH) || ((st_q == ST_RUN) && g_end);
    dec_pix  = ser_q;
    dec_pre  = !ser_q && !flush_q && (phys_q < rs_q);
    dec_win  = !ser_q && !dec_pre && !flush_q && (wrow_q < wr_q);
    dec_post = !ser_q && !dec_pre && !dec_win && (phys_q < ROWS_C);
    dec_ovr  = !ser_q && !dec_pre && !dec_win && !dec_post && (ocnt_q < ocr_q);
    dec_fin  = !(dec_pix || dec_pre || dec_win || dec_post || dec_ovr);
    bin_full = brow_q == br_q - RW'(1);
    g_start  = adv && !dec_fin;
    w_adv    = adv && dec_pix;
    w_init   = adv && (dec_ovr || (dec_win && bin_full));
    g_len    = !dec_pix ? LW'(ROW_PH) : (w_fast ? LW'(FAST_PH) : LW'(PIX_PH));
  end

  ccd_phase_gen #(.LW(LW)) i_phase_gen (
    .clk_i, .rst_ni, .start_i(g_start), .len_i(g_len),
    .active_o(g_active), .ph_o(g_ph), .end_o(g_end)
  );

  ccd_col_walk #(.CW(CW), .LEAD(LEAD)) i_col_walk (
    .clk_i, .rst_ni, .init_i(w_init), .adv_i(w_adv), .half_i(half),
    .col_start_i(cs_q), .win_cols_i(wc_q), .bin_col_i(bc_q), .oc_cols_i(occ_q),
    .fast_o(w_fast), .rst_o(w_rst), .smp_o(w_smp), .col_o(w_col), .last_o(w_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  kind_q <= SK_DUMP;
      port_q <= 2'b01;  integ_q <= '0;  flush_q <= 1'b0;
      rs_q <= '0;  wr_q <= '0;  br_q <= RW'(1);  ocr_q <= '0;
      cs_q <= '0;  wc_q <= '0;  bc_q <= CW'(1);  occ_q <= '0;
      phys_q <= '0;  wrow_q <= '0;  brow_q <= '0;  ocnt_q <= '0;
      row_q <= '0;  col_q <= '0;  ser_q <= 1'b0;
      step_rst_q <= 1'b0;  step_smp_q <= 1'b0;  done_q <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (start_i || flush_i) begin
        st_q    <= ST_LAUNCH;
        done_q  <= 1'b0;
        flush_q <= !start_i;
        port_q  <= (port_sel_i == 2'b00) ? 2'b01 : port_sel_i;
        integ_q <= integ_phase_i;
        rs_q    <= row_start_i;
        wr_q    <= (win_rows_i > MAXW_C) ? MAXW_C : win_rows_i;
        br_q    <= (bin_row_i == '0) ? RW'(1) : bin_row_i;
        ocr_q   <= start_i ? oc_rows_i : '0;
        cs_q    <= col_start_i;
        wc_q    <= win_cols_i;
        bc_q    <= (bin_col_i == '0) ? CW'(1) : bin_col_i;
        occ_q   <= oc_cols_i;
        phys_q  <= '0;  wrow_q <= '0;  brow_q <= '0;  ocnt_q <= '0;
        ser_q   <= 1'b0;
      end
    end else if (adv) begin
      st_q       <= dec_fin ? ST_IDLE : ST_RUN;
      done_q     <= dec_fin;
      step_rst_q <= 1'b0;
      step_smp_q <= 1'b0;
      if (dec_pix) begin
        kind_q     <= w_fast ? SK_FAST : SK_READ;
        step_rst_q <= w_rst;
        step_smp_q <= w_smp;
        col_q      <= w_col;
        if (w_last) ser_q <= 1'b0;
      end else if (dec_pre || dec_post) begin
        kind_q <= SK_DUMP;
        phys_q <= phys_q + RW'(1);
      end else if (dec_win) begin
        kind_q <= SK_SHIFT;
        phys_q <= phys_q + RW'(1);
        if (bin_full) begin
          brow_q <= '0;
          ser_q  <= 1'b1;
          row_q  <= wrow_q;
          wrow_q <= wrow_q + RW'(1);
        end else begin
          brow_q <= brow_q + RW'(1);
        end
      end else if (dec_ovr) begin
        kind_q <= SK_SHIFT;
        ocnt_q <= ocnt_q + RW'(1);
        ser_q  <= 1'b1;
        row_q  <= wr_q + ocnt_q;
      end
    end
  end

  always_comb begin
    row_step  = g_active && ((kind_q == SK_DUMP) || (kind_q == SK_SHIFT));
    pix_step  = g_active && ((kind_q == SK_FAST) || (kind_q == SK_READ));
    iphi_o    = (st_q == ST_IDLE) ? integ_phase_i :
                row_step ? phase_onehot(g_ph) : integ_q;
    sphi_o    = pix_step ? phase_onehot(g_ph) : 3'b000;
    dump_o    = g_active && (kind_q == SK_DUMP);
    amp_rst_o = pix_step && step_rst_q && (g_ph == 2'd0);
    sample_o  = (pix_step && g_end && step_smp_q) ? port_q : 2'b00;
    col_o     = col_q;
    row_o     = row_q;
    done_o    = done_q;
  end

  a_r12_serial_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sphi_o));
  a_r12_dump_no_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_o |-> (sphi_o == 3'b000));
  a_r4_sample_on_last_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o != 2'b00) |-> (sphi_o == 3'b100) && !done_o);
  a_r5_no_sample_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o != 2'b00) |-> !amp_rst_o);
  a_r11_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !flush_i) |=> done_o);
  a_r11_idle_integ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (iphi_o == integ_phase_i));
endmodule

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 16, LEAD = 2, ROWS = 8, MAXW = 4;
  localparam int ROW_PH = 3, PIX_PH = 2, FAST_PH = 1;
  localparam int CW = 12, RW = 12;

  typedef struct packed {
    logic [1:0]  port;
    logic [11:0] rs, wr, br, cs, wc, bc, occ, ocr;
  } vec_t;

  // R10: vector 5 has zero bins; R13: vector 8 asks for 6 rows against a limit of 4
  localparam vec_t VECS [9] = '{
    '{2'b01, 12'd2, 12'd3, 12'd1, 12'd3,  12'd4, 12'd1,  12'd0, 12'd0},
    '{2'b10, 12'd0, 12'd2, 12'd2, 12'd0,  12'd3, 12'd2,  12'd2, 12'd0},
    '{2'b11, 12'd1, 12'd2, 12'd1, 12'd2,  12'd2, 12'd3,  12'd1, 12'd2},
    '{2'b01, 12'd7, 12'd1, 12'd1, 12'd15, 12'd1, 12'd1,  12'd0, 12'd0},
    '{2'b01, 12'd0, 12'd1, 12'd8, 12'd0,  12'd1, 12'd16, 12'd3, 12'd1},
    '{2'b10, 12'd4, 12'd2, 12'd0, 12'd1,  12'd2, 12'd0,  12'd0, 12'd0},
    '{2'b01, 12'd0, 12'd0, 12'd1, 12'd0,  12'd2, 12'd1,  12'd1, 12'd2},
    '{2'b00, 12'd1, 12'd2, 12'd1, 12'd5,  12'd3, 12'd1,  12'd0, 12'd0},
    '{2'b01, 12'd0, 12'd6, 12'd1, 12'd0,  12'd2, 12'd1,  12'd0, 12'd0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, flush_i = 1'b0;
  logic [1:0] port_sel_i = 2'b01;
  logic [2:0] integ_phase_i = 3'b011;
  logic [RW-1:0] row_start_i = '0, win_rows_i = '0, bin_row_i = '0, oc_rows_i = '0;
  logic [CW-1:0] col_start_i = '0, win_cols_i = '0, bin_col_i = '0, oc_cols_i = '0;
  logic [2:0] iphi_o, sphi_o;
  logic dump_o, amp_rst_o, done_o;
  logic [1:0] sample_o;
  logic [CW-1:0] col_o;
  logic [RW-1:0] row_o;

  int tests = 0, failed = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ccd_readout_seq #(
    .COLS(COLS), .LEAD(LEAD), .ROWS(ROWS), .MAX_WIN_ROWS(MAXW), .CW(CW), .RW(RW),
    .LW(4), .ROW_PH(ROW_PH), .PIX_PH(PIX_PH), .FAST_PH(FAST_PH)
  ) i_ccd_readout_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: normal frame, 1: start and config poked mid-frame, 2: flush
  task automatic run_frame(input vec_t v, input int mode);
    int half, br, bc, wr, ocr, ser, t_exp, per, n, k, dump_n, rst_n, coord_err, mask_err;
    logic [1:0] mask;
    logic prev_rst;
    logic [2:0] ph_a, ph_b, ph_c;
    mask = (v.port == 2'b00) ? 2'b01 : v.port;
    half = (mask == 2'b11) ? COLS / 2 : COLS;
    br   = (v.br == 0) ? 1 : int'(v.br);
    bc   = (v.bc == 0) ? 1 : int'(v.bc);
    wr   = (int'(v.wr) > MAXW) ? MAXW : int'(v.wr);
    ocr  = int'(v.ocr);
    if (mode == 2) begin wr = 0; ocr = 0; end
    ser   = 3*FAST_PH*(LEAD + half - int'(v.wc)*bc) + 3*PIX_PH*(int'(v.wc)*bc + int'(v.occ));
    t_exp = 3*ROW_PH*(ROWS + ocr) + (wr + ocr)*ser;
    per   = int'(v.wc) + int'(v.occ);
    if (per == 0) per = 1;
    port_sel_i = v.port;  row_start_i = v.rs;  win_rows_i = v.wr;  bin_row_i = v.br;
    col_start_i = v.cs;   win_cols_i = v.wc;   bin_col_i = v.bc;   oc_cols_i = v.occ;
    oc_rows_i = v.ocr;
    @(negedge clk_i);
    if (mode == 2) flush_i = 1'b1; else start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;  flush_i = 1'b0;
    n = 0; k = 0; dump_n = 0; rst_n = 0; coord_err = 0; mask_err = 0;
    prev_rst = 1'b0; ph_a = '0; ph_b = '0; ph_c = '0;
    while (1) begin
      @(negedge clk_i);
      n++;
      if (mode == 1 && n == 10) begin start_i = 1'b1; win_cols_i = 12'd7; row_start_i = 12'd0; end
      if (mode == 1 && n == 11) start_i = 1'b0;
      if (n == 1) ph_a = iphi_o;
      if (n == 1 + ROW_PH) ph_b = iphi_o;
      if (n == 1 + 2*ROW_PH) ph_c = iphi_o;
      if (done_o || n > 20000) break;
      if (dump_o) dump_n++;
      if (amp_rst_o && !prev_rst) rst_n++;
      prev_rst = amp_rst_o;
      if (sample_o != 2'b00) begin
        if (sample_o != mask) mask_err++;
        if (int'(col_o) != k % per || int'(row_o) != k / per) coord_err++;
        k++;
      end
    end
    chk("R3 R6 frame length", n, t_exp + 1);
    chk("R2 R6 dump cycles", dump_n, 3*ROW_PH*(ROWS - wr*br));
    chk("R4 R8 sample count", k, (wr + ocr)*(int'(v.wc) + int'(v.occ)));
    chk("R4 R9 coordinate order errors", coord_err, 0);
    chk("R7 port mask errors", mask_err, 0);
    chk("R5 amp reset pulses", rst_n, (wr + ocr)*(LEAD + half + int'(v.occ) - int'(v.wc)*(bc - 1)));
    if (mode == 2) begin
      chk("R3 first phase", int'(ph_a), 1);
      chk("R3 second phase", int'(ph_b), 2);
      chk("R3 third phase", int'(ph_c), 4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1 iphi in reset", int'(iphi_o), 3);
    chk("R1 sphi in reset", int'(sphi_o), 0);
    chk("R1 dump in reset", int'(dump_o), 0);
    chk("R1 amp reset in reset", int'(amp_rst_o), 0);
    chk("R1 sample in reset", int'(sample_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[i]) run_frame(VECS[i], 0);

    // R11: done holds and the image clocks follow the integration pattern
    repeat (3) @(negedge clk_i);
    chk("R11 done held", int'(done_o), 1);
    integ_phase_i = 3'b110;
    #1;
    chk("R11 idle integ pattern", int'(iphi_o), 6);

    // R11: start and config changes mid-frame are ignored
    run_frame(VECS[0], 1);
    // R2: flush dumps every row, no samples
    run_frame(VECS[2], 2);
    chk("R11 done after flush", int'(done_o), 1);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule